// File: doc/BRIEF.md
# Bus-Master Storage DMA Channel Register Block

This block holds the host-visible control state of a two-channel bus-master storage DMA controller. The host reaches it through a 16-byte I/O window. Each channel owns an 8-byte slice of that window. The slice holds a command byte that starts or stops the channel and sets the transfer direction. It also holds a status byte that reports activity, drive interrupts and errors, and a 32-bit pointer to the channel's descriptor table. The transfer engine reads the start, direction and pointer values from dedicated outputs.

The host side is a plain byte-oriented register bus with address, read and write strobes, an access-size code and write data. Read data is combinational from the current state, so it is valid in the same cycle as the read strobe. Writes update the registers at the next rising clock edge. The drive side feeds one interrupt pulse and one error pulse per channel into the status byte. Only single-byte accesses take effect. Wider accesses read back as all ones and are dropped when written.

Top module: `dma_regfile`

## Requirements
- R1: After reset, every command, status and pointer byte of both channels reads 0x00, and all start and direction outputs are low.
- R2: The access-size code is 0 for one byte, 1 for two bytes and 2 or 3 for four bytes. Any access that is not one byte wide is invalid. A two-byte read returns 0x0000FFFF, a four-byte read returns 0xFFFFFFFF, and a wide write changes no register.
- R3: Channel n occupies window bytes 8n to 8n+7. Its layout is: command at channel offset 0, status at offset 2, pointer bytes at offsets 4 to 7 (least significant byte first). Offsets 1 and 3 read as 0xFF and ignore writes. A byte read returns the register in rdata bits 7:0 with the upper bits zero.
- R4: Command bit 0 is start and drives that channel's start output. Command bit 3 is direction and drives its direction output. All other command bits read as zero.
- R5: A command write copies the written start bit into status bit 0. A status write leaves status bit 0 unchanged.
- R6: On a status write, status bits 5 and 6 take the written values. Status bits 3, 4 and 7 always read as zero.
- R7: Status bits 1 and 2 are write-one-to-clear. A 1 in the write data clears the bit, and a 0 leaves it unchanged.
- R8: An interrupt pulse sets status bit 2, and an error pulse sets status bit 1. When a pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R9: The pointer is written and read a byte at a time. Its bits 1:0 always read as zero. Its full value appears on the pointer output of that channel.
- R10: An access to one channel leaves the other channel's registers and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_i | input | 4 | Byte address within the window |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| size_i | input | 2 | Access size code (0 = byte, 1 = two bytes, 2/3 = four bytes) |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 32 | Read data, zero when no read is active |
| drv_irq_i | input | 2 | Per-channel drive interrupt pulse |
| drv_err_i | input | 2 | Per-channel drive error pulse |
| start_o | output | 2 | Per-channel start flag |
| dir_o | output | 2 | Per-channel transfer direction flag |
| desc_ptr_o | output | 64 | Descriptor-table pointers, channel n in bits 32n+31:32n |

## Verification
Some rules hold at every clock edge, and the assertions check those continuously:
- reserved command and status bits stay zero, and the pointer stays dword aligned;
- a drive pulse leaves its status bit set in the next cycle;
- a status write keeps the active bit;
- a lone write-one-to-clear actually clears;
- a wide write leaves every output stable.

Other properties can only be shown by the bench's directed scenarios:
- the address decode of each channel slice;
- byte lane order in the pointer;
- the all-ones values for wide reads;
- the 0xFF filler bytes;
- isolation between channels.

// File: rtl/dma_regfile_pkg.sv
// Package: shared constants and codes for the DMA channel register block.
// Assumes byte-wide register access and 8-byte channel slices.
package dma_regfile_pkg;
    localparam int CH_BYTES = 8;
    localparam int PTR_W    = 32;
    localparam int PTR_BYTES = PTR_W / 8;

    // Access-size codes on size_i
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    // Offsets within a channel slice
    localparam logic [2:0] OFF_CMD  = 3'd0;
    localparam logic [2:0] OFF_STAT = 3'd2;
    localparam logic [2:0] OFF_PTR  = 3'd4;

    // Command bits
    localparam int START_BIT = 0;
    localparam int DIR_BIT   = 3;
    localparam logic [7:0] CMD_MASK = 8'h09;

    // Status bits
    localparam int ACT_BIT = 0;
    localparam int ERR_BIT = 1;
    localparam int IRQ_BIT = 2;
    localparam logic [7:0] STAT_RW_MASK  = 8'h60;
    localparam logic [7:0] STAT_W1C_MASK = 8'h06;
    localparam logic [7:0] STAT_ACT_MASK = 8'h01;
    localparam logic [7:0] STAT_RSVD     = 8'h98;

    localparam logic [7:0] FILL_BYTE = 8'hFF;
endpackage

// File: rtl/dma_chan_regs.sv
// Module: one channel's command, status and descriptor pointer registers.
// Assumes the parent has already qualified wr_sel as a valid byte write
// to this channel; off is the offset inside the channel slice.
module dma_chan_regs
    import dma_regfile_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic [2:0]       off,
    input  logic [7:0]       wbyte,
    input  logic             irq_pulse,
    input  logic             err_pulse,
    output logic [7:0]       cmd_q,
    output logic [7:0]       stat_q,
    output logic [PTR_W-1:0] ptr_q
);
    logic       cmd_we;
    logic       stat_we;
    logic [7:0] stat_d;

    assign cmd_we  = wr_sel && (off == OFF_CMD);
    assign stat_we = wr_sel && (off == OFF_STAT);

    // Command register: keep only the start and direction bits
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (cmd_we) cmd_q <= wbyte & CMD_MASK;
    end

    // Next status: write rules first, then the active mirror, then drive pulses
    always_comb begin
        stat_d = stat_q;
        if (stat_we) begin
            stat_d = (wbyte & STAT_RW_MASK)
                   | (stat_q & STAT_ACT_MASK)
                   | (stat_q & ~wbyte & STAT_W1C_MASK);
        end
        if (cmd_we)    stat_d[ACT_BIT] = wbyte[START_BIT];
        if (err_pulse) stat_d[ERR_BIT] = 1'b1;
        if (irq_pulse) stat_d[IRQ_BIT] = 1'b1;
    end

    // Status register
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    // Pointer register: byte lanes, low two bits forced to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (wr_sel && off[2]) begin
            for (int k = 0; k < PTR_BYTES; k++) begin
                if (off[1:0] == 2'(k)) begin
                    ptr_q[8*k +: 8] <= (k == 0) ? (wbyte & 8'hFC) : wbyte;
                end
            end
        end
    end

    AST_CMD_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q & ~CMD_MASK) == 8'h00); // R4
    AST_STAT_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & STAT_RSVD) == 8'h00); // R6
    AST_ACTIVE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we && !cmd_we |=> stat_q[ACT_BIT] == $past(stat_q[ACT_BIT])); // R5
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we && wbyte[IRQ_BIT] && !irq_pulse |=> !stat_q[IRQ_BIT]); // R7
    AST_IRQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> stat_q[IRQ_BIT]); // R8
    AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> stat_q[ERR_BIT]); // R8
    AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q[1:0] == 2'b00); // R9
endmodule

// File: rtl/dma_read_mux.sv
// Module: combinational read path for the register window.
// Assumes channel state arrives as packed arrays indexed by channel and
// that a non-byte access must return all ones across its width.
module dma_read_mux
    import dma_regfile_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = $clog2(NCH * CH_BYTES)
) (
    input  logic                      rd_en,
    input  logic [1:0]                size,
    input  logic [AW-1:0]             addr,
    input  logic [NCH-1:0][7:0]       cmd,
    input  logic [NCH-1:0][7:0]       stat,
    input  logic [NCH-1:0][PTR_W-1:0] ptr,
    output logic [31:0]               rdata
);
    localparam int CHW = AW - 3;

    logic [CHW-1:0] ch;
    logic [2:0]     off;
    logic [7:0]     byte_val;

    assign ch  = addr[AW-1:3];
    assign off = addr[2:0];

    // Select the addressed byte within the addressed channel
    always_comb begin
        byte_val = FILL_BYTE;
        if (off[2]) begin
            byte_val = ptr[ch][8*off[1:0] +: 8];
        end else if (off == OFF_CMD) begin
            byte_val = cmd[ch];
        end else if (off == OFF_STAT) begin
            byte_val = stat[ch];
        end
    end

    // Size handling: byte reads are zero-extended, wider reads are all ones
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (acc_size_e'(size))
                SZ_BYTE: rdata = {24'h000000, byte_val};
                SZ_HALF: rdata = 32'h0000FFFF;
                default: rdata = 32'hFFFFFFFF;
            endcase
        end
    end
endmodule

// File: rtl/dma_regfile.sv
// Module: top of the DMA channel register block.
// Decodes byte writes to per-channel slices, instantiates one register set
// per channel and the shared read path. Assumes single-cycle strobes.
module dma_regfile
    import dma_regfile_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = $clog2(NCH * CH_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        addr_i,
    input  logic                 rd_en_i,
    input  logic                 wr_en_i,
    input  logic [1:0]           size_i,
    input  logic [7:0]           wdata_i,
    output logic [31:0]          rdata_o,
    input  logic [NCH-1:0]       drv_irq_i,
    input  logic [NCH-1:0]       drv_err_i,
    output logic [NCH-1:0]       start_o,
    output logic [NCH-1:0]       dir_o,
    output logic [NCH*PTR_W-1:0] desc_ptr_o
);
    localparam int CHW = AW - 3;

    logic                      byte_wr;
    logic [NCH-1:0][7:0]       cmd;
    logic [NCH-1:0][7:0]       stat;
    logic [NCH-1:0][PTR_W-1:0] ptr;

    // Only byte-sized writes reach the registers
    assign byte_wr = wr_en_i && (acc_size_e'(size_i) == SZ_BYTE);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel;
        assign sel = byte_wr && (addr_i[AW-1:3] == CHW'(i));

        dma_chan_regs u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_sel    (sel),
            .off       (addr_i[2:0]),
            .wbyte     (wdata_i),
            .irq_pulse (drv_irq_i[i]),
            .err_pulse (drv_err_i[i]),
            .cmd_q     (cmd[i]),
            .stat_q    (stat[i]),
            .ptr_q     (ptr[i])
        );

        assign start_o[i] = cmd[i][START_BIT];
        assign dir_o[i]   = cmd[i][DIR_BIT];
        assign desc_ptr_o[i*PTR_W +: PTR_W] = ptr[i];
    end

    dma_read_mux #(.NCH(NCH), .AW(AW)) u_rd (
        .rd_en (rd_en_i),
        .size  (size_i),
        .addr  (addr_i),
        .cmd   (cmd),
        .stat  (stat),
        .ptr   (ptr),
        .rdata (rdata_o)
    );

    AST_WIDE_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && (size_i != 2'd0)
        |=> $stable(start_o) && $stable(dir_o) && $stable(desc_ptr_o)); // R2
endmodule

// File: tb/test_dma_regfile.sv
// Bench: directed scenarios for the DMA channel register block.
module test_dma_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  size = '0;
    logic [7:0]  wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq = '0;
    logic [1:0]  err = '0;
    logic [1:0]  start;
    logic [1:0]  dir;
    logic [63:0] ptr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dma_regfile i_dma_regfile (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .rd_en_i(rd_en),
        .wr_en_i(wr_en), .size_i(size), .wdata_i(wdata), .rdata_o(rdata),
        .drv_irq_i(irq), .drv_err_i(err), .start_o(start), .dir_o(dir),
        .desc_ptr_o(ptr)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic [1:0] s);
        @(negedge clk);
        addr = a; wdata = d; size = s; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; size = 2'd0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        addr = a; size = s; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0; size = 2'd0;
    endtask

    task automatic pulse(input logic [1:0] i, input logic [1:0] e);
        @(negedge clk);
        irq = i; err = e;
        @(negedge clk);
        irq = '0; err = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int a = 0; a < 16; a++) begin
            if (a % 8 != 1 && a % 8 != 3) begin
                rd(4'(a), 2'd0, d);
                check("R1 reset byte", d, 0);
            end
        end
        check("R1 start after reset", start, 0);
        check("R1 dir after reset", dir, 0);
        check("R1 ptr after reset", ptr, 0);
    endtask

    task automatic t_command;
        logic [31:0] d;
        wr(4'd0, 8'hFF, 2'd0);
        rd(4'd0, 2'd0, d);
        check("R4 cmd reserved bits zero", d, 32'h09);
        check("R4 start out", start, 2'b01);
        check("R4 dir out", dir, 2'b01);
        rd(4'd2, 2'd0, d);
        check("R5 active follows start", d, 32'h01);
        wr(4'd0, 8'h08, 2'd0);
        check("R4 start cleared", start, 2'b00);
        rd(4'd2, 2'd0, d);
        check("R5 active cleared", d, 32'h00);
        wr(4'd0, 8'h01, 2'd0);
    endtask

    task automatic t_status_rw;
        logic [31:0] d;
        wr(4'd2, 8'hFF, 2'd0);
        rd(4'd2, 2'd0, d);
        check("R6 rw bits set, active kept", d, 32'h61);
        wr(4'd2, 8'h00, 2'd0);
        rd(4'd2, 2'd0, d);
        check("R5 status write keeps active", d, 32'h01);
    endtask

    task automatic t_w1c;
        logic [31:0] d;
        pulse(2'b01, 2'b01);
        rd(4'd2, 2'd0, d);
        check("R8 irq and err set", d, 32'h07);
        wr(4'd2, 8'h04, 2'd0);
        rd(4'd2, 2'd0, d);
        check("R7 clear irq only", d, 32'h03);
        wr(4'd2, 8'h02, 2'd0);
        rd(4'd2, 2'd0, d);
        check("R7 clear err", d, 32'h01);
    endtask

    task automatic t_set_wins;
        logic [31:0] d;
        pulse(2'b01, 2'b00);
        @(negedge clk);
        addr = 4'd2; wdata = 8'h06; size = 2'd0; wr_en = 1'b1; irq = 2'b01;
        @(negedge clk);
        wr_en = 1'b0; irq = '0;
        rd(4'd2, 2'd0, d);
        check("R8 set beats clear", d, 32'h05);
        wr(4'd2, 8'h04, 2'd0);
    endtask

    task automatic t_pointer;
        logic [31:0] d;
        wr(4'd12, 8'h13, 2'd0);
        wr(4'd13, 8'h22, 2'd0);
        wr(4'd14, 8'h33, 2'd0);
        wr(4'd15, 8'h44, 2'd0);
        check("R9 ch1 pointer out", ptr[63:32], 32'h44332210);
        rd(4'd12, 2'd0, d);
        check("R9 low bits read zero", d, 32'h10);
        rd(4'd15, 2'd0, d);
        check("R3 pointer top byte", d, 32'h44);
        check("R10 ch0 pointer untouched", ptr[31:0], 0);
    endtask

    task automatic t_reserved;
        logic [31:0] d;
        wr(4'd1, 8'h55, 2'd0);
        wr(4'd3, 8'hAA, 2'd0);
        rd(4'd1, 2'd0, d);
        check("R3 offset 1 fill", d, 32'hFF);
        rd(4'd11, 2'd0, d);
        check("R3 offset 3 fill", d, 32'hFF);
        rd(4'd0, 2'd0, d);
        check("R3 cmd unchanged by reserved writes", d, 32'h01);
        rd(4'd2, 2'd0, d);
        check("R3 status unchanged by reserved writes", d, 32'h01);
    endtask

    task automatic t_wide;
        logic [31:0] d;
        rd(4'd0, 2'd1, d);
        check("R2 two-byte read", d, 32'h0000FFFF);
        rd(4'd0, 2'd2, d);
        check("R2 four-byte read", d, 32'hFFFFFFFF);
        rd(4'd4, 2'd3, d);
        check("R2 size 3 read", d, 32'hFFFFFFFF);
        wr(4'd0, 8'h00, 2'd2);
        wr(4'd4, 8'hF0, 2'd1);
        check("R2 wide write ignored start", start, 2'b01);
        check("R2 wide write ignored ptr", ptr[31:0], 0);
        rd(4'd0, 2'd0, d);
        check("R2 cmd kept", d, 32'h01);
    endtask

    task automatic t_independent;
        logic [31:0] d;
        wr(4'd8, 8'h09, 2'd0);
        check("R10 ch1 start", start, 2'b11);
        check("R10 ch1 dir", dir, 2'b10);
        pulse(2'b10, 2'b00);
        rd(4'd10, 2'd0, d);
        check("R10 ch1 status", d, 32'h05);
        rd(4'd2, 2'd0, d);
        check("R10 ch0 status untouched", d, 32'h01);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_command;
        t_status_rw;
        t_w1c;
        t_set_wins;
        t_pointer;
        t_reserved;
        t_wide;
        t_independent;
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run;
    end
endmodule